// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block derives a periodic event from a 32.768 kHz time base inside a real-time clock. A one-cycle tick enable marks each cycle of that time base; the block counts ticks in a free-running counter and raises an event whenever the count reaches a multiple of the selected period. A 4-bit rate code sets the period as a power of two. Two legacy codes are folded onto slower rates, and code zero switches the event off.

Every event produces a one-cycle pulse that sets the periodic flag. A second pulse, the interrupt request, appears only when the periodic-interrupt enable is on. A third pulse drives the square-wave output when the square-wave enable is on. Events fall on boundaries of the running count, not a fixed delay after enabling. A new rate code therefore takes effect at the next boundary of the new period without any stray pulse. When the divider-control field holds the divider in reset, the count is cleared and no event is produced.

Top module: `periodic_rate_gen`

## Requirements
- R1: A rate code of 0 produces no event on any output, whatever the enables are.
- R2: Rate code 1 behaves exactly like code 8 (period 128 ticks), and rate code 2 behaves exactly like code 9 (period 256 ticks).
- R3: For an effective code n in 3..15, events occur every 2^(n-1) ticks, for example every 4 ticks for code 3 and every 16384 ticks for code 15.
- R4: When the periodic-interrupt enable and the square-wave enable are both 0, no event is produced.
- R5: The tick count starts at 0 when the divider leaves reset. An event occurs on the tick that brings the count to a nonzero multiple of the period, so the first event comes on tick p.
- R6: Each event gives a one-cycle pulse on `pf_set`. `irq_set` pulses together with it only when `pie` is 1.
- R7: With `sqwe` at 1, each event gives a one-cycle pulse on `sqw_pulse` rather than a level wave. With `sqwe` at 0, `sqw_pulse` stays 0.
- R8: When `div_ctrl[2:1]` equals 2'b11 (values 6 and 7), the divider is held in reset: the count is cleared and no event is produced, even while ticks arrive.
- R9: A change of rate code lands the next event on the next multiple of the new period in the running count, with no extra pulse on the change.
- R10: The outputs rise in the clock cycle after the tick that completes a boundary, and they last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable marking a 32.768 kHz time-base cycle |
| rate_code | input | 4 | Rate select; 0 turns the event off |
| div_ctrl | input | 3 | Divider-control field; 2'b11 in bits 2:1 holds the divider in reset |
| pie | input | 1 | Periodic-interrupt enable |
| sqwe | input | 1 | Square-wave enable |
| pf_set | output | 1 | One-cycle pulse that sets the periodic flag |
| irq_set | output | 1 | One-cycle interrupt-request pulse, qualified by `pie` |
| sqw_pulse | output | 1 | One-cycle square-wave output pulse, qualified by `sqwe` |

## Verification
The bench uses the default parameters: a 16-bit count and a 4-bit code. At these values every rate from 4 to 16384 ticks can be reached in a short run. The bench drives one tick per cycle for the rate table, so the slowest code, 15, completes a full period within the cycle budget. A gapped tick pattern shows that each pulse lasts one clock. Counter wrap-around at 2^16 is not exercised. The wrap value is a multiple of every period, so reaching it would add no new boundary case.

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen #(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] rate_code,
  input  logic [2:0]        div_ctrl,
  input  logic              pie,
  input  logic              sqwe,
  output logic              pf_set,
  output logic              irq_set,
  output logic              sqw_pulse
);
  localparam logic [CODE_W-1:0] SLOW_A = CODE_W'(8);
  localparam logic [CODE_W-1:0] SLOW_B = CODE_W'(9);

  logic [CNT_W-1:0]  cnt, cnt_nxt, mask;
  logic [CODE_W-1:0] eff_code;
  logic              div_hold, running, hit;

  assign div_hold = (div_ctrl[2:1] == 2'b11);
  assign eff_code = (rate_code == CODE_W'(1)) ? SLOW_A :
                    (rate_code == CODE_W'(2)) ? SLOW_B : rate_code;
  assign cnt_nxt  = cnt + 1'b1;
  assign running  = !div_hold && (eff_code != '0) && (pie || sqwe);
  assign hit      = tick && running && ((cnt_nxt & mask) == '0);

  always_comb begin
    for (int i = 0; i < CNT_W; i++)
      mask[i] = (i + 1 < int'(eff_code));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      pf_set    <= 1'b0;
      irq_set   <= 1'b0;
      sqw_pulse <= 1'b0;
    end else begin
      if (div_hold)  cnt <= '0;
      else if (tick) cnt <= cnt_nxt;
      pf_set    <= hit;
      irq_set   <= hit && pie;
      sqw_pulse <= hit && sqwe;
    end
  end
endmodule

module periodic_rate_gen_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [CODE_W-1:0] rate_code,
  input logic [2:0]        div_ctrl,
  input logic              pie,
  input logic              sqwe,
  input logic              pf_set,
  input logic              irq_set,
  input logic              sqw_pulse
);
  p_code0_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pf_set |-> $past(rate_code) != '0);
  p_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pf_set |-> $past(tick));
  p_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pf_set |-> $past(pie || sqwe));
  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> (pf_set && $past(pie)));
  p_sqw_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sqw_pulse |-> (pf_set && $past(sqwe)));
  p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(div_ctrl[2:1] == 2'b11) |-> !pf_set);
  p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pf_set |=> !pf_set);
endmodule

bind periodic_rate_gen periodic_rate_gen_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/test_periodic_rate_gen.sv
`timescale 1ns/1ps
module test_periodic_rate_gen;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pie = 1'b0, sqwe = 1'b0;
  logic [3:0] rate_code = '0;
  logic [2:0] div_ctrl = 3'b010;
  logic pf_set, irq_set, sqw_pulse;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  periodic_rate_gen i_periodic_rate_gen (.*);

  // code, pie, sqwe, ticks, pf count, irq count, sqw count, first event tick
  localparam int NV = 11;
  localparam int VEC [NV][8] = '{
    '{3,  1, 0, 40,    10, 10, 0,  4},
    '{4,  0, 1, 40,    5,  0,  5,  8},
    '{1,  1, 1, 300,   2,  2,  2,  128},
    '{8,  1, 1, 300,   2,  2,  2,  128},
    '{2,  1, 1, 600,   2,  2,  2,  256},
    '{0,  1, 1, 100,   0,  0,  0,  0},
    '{5,  0, 0, 100,   0,  0,  0,  0},
    '{15, 1, 0, 20000, 1,  1,  0,  16384},
    '{6,  1, 0, 33,    1,  1,  0,  32},
    '{9,  0, 1, 255,   0,  0,  0,  0},
    '{9,  0, 1, 256,   1,  0,  1,  256}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_ticks(input int n, output int npf, output int nirq,
                           output int nsqw, output int first);
    npf = 0; nirq = 0; nsqw = 0; first = 0;
    tick = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (pf_set) begin npf++; if (first == 0) first = i; end
      if (irq_set) nirq++;
      if (sqw_pulse) nsqw++;
      if (i == n) tick = 1'b0;
    end
  endtask

  task automatic restart(input int code, input int p, input int s);
    div_ctrl = 3'b110;
    rate_code = 4'(code); pie = p[0]; sqwe = s[0];
    @(negedge clk); @(negedge clk);
    div_ctrl = 3'b010;
  endtask

  initial begin
    int a, b, c, f;
    repeat (3) @(negedge clk);
    // R6 R7: reset state
    chk("R6", "pf_set in reset", int'(pf_set), 0);
    chk("R6", "irq_set in reset", int'(irq_set), 0);
    chk("R7", "sqw_pulse in reset", int'(sqw_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5 R6 R7: rate table
    for (int v = 0; v < NV; v++) begin
      restart(VEC[v][0], VEC[v][1], VEC[v][2]);
      run_ticks(VEC[v][3], a, b, c, f);
      chk("R3", $sformatf("vec%0d pf count", v), a, VEC[v][4]);
      chk("R6", $sformatf("vec%0d irq count", v), b, VEC[v][5]);
      chk("R7", $sformatf("vec%0d sqw count", v), c, VEC[v][6]);
      chk("R5", $sformatf("vec%0d first event tick", v), f, VEC[v][7]);
    end

    // R9: rate changes realign to new boundary
    restart(6, 1, 0);
    run_ticks(40, a, b, c, f);
    chk("R9", "p32 events in 40 ticks", a, 1);
    rate_code = 4'd3;
    @(negedge clk);
    chk("R9", "no pulse on code change", int'(pf_set), 0);
    run_ticks(8, a, b, c, f);
    chk("R9", "first event after switch to p4", f, 4);
    chk("R9", "events count 41..48 at p4", a, 2);
    rate_code = 4'd7;
    run_ticks(20, a, b, c, f);
    chk("R9", "first event after switch to p64", f, 16);

    // R8: divider hold clears count and blocks events
    restart(3, 1, 1);
    run_ticks(3, a, b, c, f);
    div_ctrl = 3'b111;
    run_ticks(50, a, b, c, f);
    chk("R8", "events while divider held", a, 0);
    div_ctrl = 3'b010;
    run_ticks(4, a, b, c, f);
    chk("R8", "first event after release", f, 4);

    // R10: gapped ticks, one-cycle pulse
    restart(3, 1, 1);
    for (int k = 1; k <= 4; k++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      chk("R10", $sformatf("pf after tick %0d", k), int'(pf_set), k == 4 ? 1 : 0);
      @(negedge clk);
      chk("R10", $sformatf("pf in gap after tick %0d", k), int'(pf_set), 0);
      chk("R10", $sformatf("sqw in gap after tick %0d", k), int'(sqw_pulse), 0);
      @(negedge clk);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule